// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank for Display Windows

This block keeps the configuration of five display windows in two copies. Software writes a pending copy through a simple register bus and reads it back. The display pipeline sees only the active copy, which is driven on parallel output buses. The pending values move into the active copy only in the clock cycle where the timing generator raises its vsync-start pulse. That is the same instant a new frame fetch begins, so a frame never starts with a half-updated window.

Each window holds these registers: a control word, a buffer start address, a stride word and a position word. It also holds a size word. The stride word splits into the bytes fetched per line and the bytes skipped after each line. The buffer end address is not written by software. The bank derives it from the start address, the full line length (fetched plus skipped bytes) and the window height.

One global shadow-control word holds two bits for each window, side by side: a fetch-channel enable and a protect bit. While a window's protect bit is set, its pending values stay pending across any number of vsync pulses. Software can therefore rewrite several registers of a window and then release them all together. The channel enables act at once and are not shadowed.

Top module: `shadow_bank`

## Requirements
- R1: After reset, every active output bus and the channel-enable output are zero, the protect bits are clear, and every register reads back as zero.
- R2: A write to a window register changes only the pending copy. The read data at that address shows the new value from the next cycle on, and the active outputs stay unchanged until a vsync-start pulse.
- R3: In a cycle where vsyncStart is high, every unprotected window copies all of its pending registers into its active outputs at once. The new values appear after that clock edge.
- R4: A window whose protect bit is set when vsyncStart is high keeps its active outputs unchanged.
- R5: After a protect bit is cleared, the active outputs of that window keep their old values until the next vsync-start pulse, which then copies the pending values.
- R6: Address 0xF0 is the shadow-control word. Bits [4:0] are the channel enables for windows 0 to 4 and bits [12:8] are the protect bits for windows 0 to 4; all other bits read as zero. chanEn follows a write from the next cycle on, with no wait for vsync.
- R7: Window registers sit at address {window[3:0], reg[3:0]} with reg 0 control, 1 start, 2 stride, 3 position, 4 size and 5 end. The end address equals start + (skip + pageWidth) × height, truncated to 32 bits. It is readable at reg 5 from the pending values and is copied to actEnd at vsync together with the other registers.
- R8: In the stride word, pageWidth is bits [15:0] and skip is bits [31:16]. Position (x in [11:0], y in [27:16]) and size (width in [11:0], height in [27:16]) keep only those bits, so the other bits read as zero.
- R9: A write to reg 5, to a reg index above 5, or to window index 5 to 14 changes no register, and reads of such addresses return zero.
- R10: When a register write and vsyncStart fall in the same cycle, the copy uses the value from before the write. The written value reaches the active outputs at a later vsync. A protect-bit write in that cycle likewise acts only from the next vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write address {window, reg} |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read address {window, reg} |
| rdData | output | 32 | Pending value at rdAddr (combinational) |
| vsyncStart | input | 1 | One-cycle frame-start pulse |
| actCtrl | output | 160 | Active control words, window i at [32i+31:32i] |
| actStart | output | 160 | Active buffer start addresses |
| actEnd | output | 160 | Active buffer end addresses |
| actStride | output | 160 | Active stride words |
| actPos | output | 160 | Active position words |
| actSize | output | 160 | Active size words |
| chanEn | output | 5 | Fetch-channel enable per window |

## Verification
A write is due at rdData one clock edge later. The bench samples rdData 1 ns after that edge, once rdAddr has been set. The active buses and actEnd change on the edge that samples vsyncStart, and chanEn changes on the edge that samples a shadow-control write. The bench therefore advances its reference model once per edge, using the inputs held during that cycle, and compares every output 1 ns after the edge. For the same-cycle case, the model applies the copy before the write, which matches the requirement.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int NumWin  = 5;
  localparam int DataW   = 32;
  localparam int AddrW   = 8;
  localparam int FieldW  = 4;
  localparam int WinSelW = $clog2(NumWin);
  localparam int ProtLsb = 8;

  localparam logic [FieldW-1:0] GlobalWin = 4'hF;
  localparam logic [FieldW-1:0] RegCtrl   = 4'd0;
  localparam logic [FieldW-1:0] RegStart  = 4'd1;
  localparam logic [FieldW-1:0] RegStride = 4'd2;
  localparam logic [FieldW-1:0] RegPos    = 4'd3;
  localparam logic [FieldW-1:0] RegSize   = 4'd4;
  localparam logic [FieldW-1:0] RegEnd    = 4'd5;

  localparam logic [DataW-1:0] XyMask = 32'h0FFF_0FFF;

  typedef struct packed {
    logic [NumWin-1:0] wrCtrl;
    logic [NumWin-1:0] wrStart;
    logic [NumWin-1:0] wrStride;
    logic [NumWin-1:0] wrPos;
    logic [NumWin-1:0] wrSize;
    logic [NumWin-1:0] latch;
    logic [DataW-1:0]  wrData;
    logic [FieldW-1:0] rdWin;
    logic [FieldW-1:0] rdReg;
    logic              rdGlobal;
  } bankStrobe_t;

  typedef struct packed {
    logic [DataW-1:0] ctrl;
    logic [DataW-1:0] start;
    logic [DataW-1:0] stride;
    logic [DataW-1:0] pos;
    logic [DataW-1:0] size;
  } winCfg_t;
endpackage

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import shadow_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [AddrW-1:0] rdAddr,
  input  logic             vsyncStart,
  output bankStrobe_t      strobe,
  output logic [DataW-1:0] shadowWord,
  output logic [NumWin-1:0] chanEn
);
  logic [NumWin-1:0] protectQ;
  logic [NumWin-1:0] enableQ;
  logic [FieldW-1:0] winW;
  logic [FieldW-1:0] regW;
  logic              globalWr;

  assign winW     = wrAddr[AddrW-1 -: FieldW];
  assign regW     = wrAddr[FieldW-1:0];
  assign globalWr = wrEn && (winW == GlobalWin) && (regW == RegCtrl);

  always_ff @(posedge clk) begin
    if (rst) begin
      protectQ <= '0;
      enableQ  <= '0;
    end else if (globalWr) begin
      enableQ  <= wrData[NumWin-1:0];
      protectQ <= wrData[ProtLsb +: NumWin];
    end
  end

  always_comb begin
    shadowWord = '0;
    shadowWord[NumWin-1:0]        = enableQ;
    shadowWord[ProtLsb +: NumWin] = protectQ;
  end

  assign chanEn = enableQ;

  for (genvar i = 0; i < NumWin; i++) begin : g_dec
    logic hit;
    assign hit = wrEn && (winW == FieldW'(i));
    assign strobe.wrCtrl[i]   = hit && (regW == RegCtrl);
    assign strobe.wrStart[i]  = hit && (regW == RegStart);
    assign strobe.wrStride[i] = hit && (regW == RegStride);
    assign strobe.wrPos[i]    = hit && (regW == RegPos);
    assign strobe.wrSize[i]   = hit && (regW == RegSize);
    assign strobe.latch[i]    = vsyncStart && !protectQ[i];
  end

  assign strobe.wrData   = wrData;
  assign strobe.rdWin    = rdAddr[AddrW-1 -: FieldW];
  assign strobe.rdReg    = rdAddr[FieldW-1:0];
  assign strobe.rdGlobal = (rdAddr[AddrW-1 -: FieldW] == GlobalWin) &&
                           (rdAddr[FieldW-1:0] == RegCtrl);
endmodule

// File: rtl/shadow_bank_dp.sv
module shadow_bank_dp
  import shadow_bank_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  bankStrobe_t             strobe,
  input  logic [DataW-1:0]        shadowWord,
  output logic [DataW-1:0]        rdData,
  output logic [NumWin*DataW-1:0] actCtrl,
  output logic [NumWin*DataW-1:0] actStart,
  output logic [NumWin*DataW-1:0] actEnd,
  output logic [NumWin*DataW-1:0] actStride,
  output logic [NumWin*DataW-1:0] actPos,
  output logic [NumWin*DataW-1:0] actSize
);
  winCfg_t          pendQ   [NumWin];
  winCfg_t          actQ    [NumWin];
  logic [DataW-1:0] actEndQ [NumWin];
  logic [DataW-1:0] pendEnd [NumWin];

  for (genvar i = 0; i < NumWin; i++) begin : g_win
    logic [DataW-1:0] lineBytes;
    logic [DataW-1:0] rows;
    assign lineBytes  = DataW'(pendQ[i].stride[31:16]) + DataW'(pendQ[i].stride[15:0]);
    assign rows       = DataW'(pendQ[i].size[27:16]);
    assign pendEnd[i] = pendQ[i].start + lineBytes * rows;

    assign actCtrl  [i*DataW +: DataW] = actQ[i].ctrl;
    assign actStart [i*DataW +: DataW] = actQ[i].start;
    assign actStride[i*DataW +: DataW] = actQ[i].stride;
    assign actPos   [i*DataW +: DataW] = actQ[i].pos;
    assign actSize  [i*DataW +: DataW] = actQ[i].size;
    assign actEnd   [i*DataW +: DataW] = actEndQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NumWin; i++) begin
        pendQ[i]   <= '0;
        actQ[i]    <= '0;
        actEndQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NumWin; i++) begin
        if (strobe.latch[i]) begin
          actQ[i]    <= pendQ[i];
          actEndQ[i] <= pendEnd[i];
        end
        if (strobe.wrCtrl[i])   pendQ[i].ctrl   <= strobe.wrData;
        if (strobe.wrStart[i])  pendQ[i].start  <= strobe.wrData;
        if (strobe.wrStride[i]) pendQ[i].stride <= strobe.wrData;
        if (strobe.wrPos[i])    pendQ[i].pos    <= strobe.wrData & XyMask;
        if (strobe.wrSize[i])   pendQ[i].size   <= strobe.wrData & XyMask;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdGlobal) begin
      rdData = shadowWord;
    end else if (strobe.rdWin < FieldW'(NumWin)) begin
      case (strobe.rdReg)
        RegCtrl:   rdData = pendQ[strobe.rdWin[WinSelW-1:0]].ctrl;
        RegStart:  rdData = pendQ[strobe.rdWin[WinSelW-1:0]].start;
        RegStride: rdData = pendQ[strobe.rdWin[WinSelW-1:0]].stride;
        RegPos:    rdData = pendQ[strobe.rdWin[WinSelW-1:0]].pos;
        RegSize:   rdData = pendQ[strobe.rdWin[WinSelW-1:0]].size;
        RegEnd:    rdData = pendEnd[strobe.rdWin[WinSelW-1:0]];
        default:   rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int Windows = NumWin,
  parameter int Width   = DataW,
  parameter int AddrBits = AddrW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wrEn,
  input  logic [AddrBits-1:0]       wrAddr,
  input  logic [Width-1:0]          wrData,
  input  logic [AddrBits-1:0]       rdAddr,
  output logic [Width-1:0]          rdData,
  input  logic                      vsyncStart,
  output logic [Windows*Width-1:0]  actCtrl,
  output logic [Windows*Width-1:0]  actStart,
  output logic [Windows*Width-1:0]  actEnd,
  output logic [Windows*Width-1:0]  actStride,
  output logic [Windows*Width-1:0]  actPos,
  output logic [Windows*Width-1:0]  actSize,
  output logic [Windows-1:0]        chanEn
);
  bankStrobe_t      strobe;
  logic [DataW-1:0] shadowWord;

  shadow_bank_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .vsyncStart(vsyncStart), .strobe(strobe),
    .shadowWord(shadowWord), .chanEn(chanEn)
  );

  shadow_bank_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .shadowWord(shadowWord),
    .rdData(rdData), .actCtrl(actCtrl), .actStart(actStart), .actEnd(actEnd),
    .actStride(actStride), .actPos(actPos), .actSize(actSize)
  );
endmodule

// File: rtl/shadow_bank_checker.sv
module shadow_bank_checker
  import shadow_bank_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    vsyncStart,
  input logic                    wrEn,
  input logic [AddrW-1:0]        wrAddr,
  input logic [DataW-1:0]        wrData,
  input logic [DataW-1:0]        shadowWord,
  input logic [NumWin*DataW-1:0] actCtrl,
  input logic [NumWin*DataW-1:0] actStart,
  input logic [NumWin*DataW-1:0] actEnd,
  input logic [NumWin*DataW-1:0] actStride,
  input logic [NumWin*DataW-1:0] actPos,
  input logic [NumWin*DataW-1:0] actSize,
  input logic [NumWin-1:0]       chanEn
);
  logic rstSeen = 1'b0;

  always @(posedge clk) begin
    if (rstSeen) begin
      p_reset_zero_r1: assert (chanEn == '0 && actCtrl == '0 && actStart == '0 && actEnd == '0)
        else $error("active state not cleared by reset");
    end
    rstSeen <= rst;
  end

  p_hold_no_vsync_r2: assert property (@(posedge clk) disable iff (rst)
    !vsyncStart |=> $stable(actCtrl) && $stable(actStart) && $stable(actEnd) &&
                    $stable(actStride) && $stable(actPos) && $stable(actSize));

  p_chan_direct_r6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 8'hF0) |=> chanEn == $past(wrData[NumWin-1:0]));

  for (genvar i = 0; i < NumWin; i++) begin : g_chk
    p_protect_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (vsyncStart && shadowWord[ProtLsb + i]) |=>
        $stable(actCtrl[i*DataW +: DataW]) && $stable(actStart[i*DataW +: DataW]) &&
        $stable(actEnd[i*DataW +: DataW]) && $stable(actSize[i*DataW +: DataW]));

    p_end_sum_r7: assert property (@(posedge clk) disable iff (rst)
      actEnd[i*DataW +: DataW] == actStart[i*DataW +: DataW] +
        (32'(actStride[i*DataW+16 +: 16]) + 32'(actStride[i*DataW +: 16])) *
        32'(actSize[i*DataW+16 +: 12]));
  end
endmodule

bind shadow_bank shadow_bank_checker u_chk (
  .clk(clk), .rst(rst), .vsyncStart(vsyncStart), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .shadowWord(shadowWord), .actCtrl(actCtrl), .actStart(actStart),
  .actEnd(actEnd), .actStride(actStride), .actPos(actPos), .actSize(actSize),
  .chanEn(chanEn)
);

// File: tb/shadow_bank_bench.sv
module shadow_bank_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wrEn = 1'b0;
  logic [7:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic [7:0]   rdAddr = '0;
  logic         vsyncStart = 1'b0;
  logic [31:0]  rdData;
  logic [159:0] actCtrl, actStart, actEnd, actStride, actPos, actSize;
  logic [4:0]   chanEn;

  shadow_bank u_shadow_bank (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .vsyncStart(vsyncStart),
    .actCtrl(actCtrl), .actStart(actStart), .actEnd(actEnd), .actStride(actStride),
    .actPos(actPos), .actSize(actSize), .chanEn(chanEn)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [31:0] mPend [5][5];
  logic [31:0] mAct  [5][5];
  logic [31:0] mActEnd [5];
  logic [4:0]  mProt, mEn;

  function automatic logic [31:0] endOf(input logic [31:0] st, input logic [31:0] sd,
                                        input logic [31:0] sz);
    return st + (32'(sd[31:16]) + 32'(sd[15:0])) * 32'(sz[27:16]);
  endfunction

  function automatic logic [31:0] readExp(input logic [7:0] a);
    int w = int'(a[7:4]);
    int r = int'(a[3:0]);
    if (w == 15 && r == 0) return {19'b0, mProt, 3'b0, mEn};
    if (w < 5 && r < 5) return mPend[w][r];
    if (w < 5 && r == 5) return endOf(mPend[w][1], mPend[w][2], mPend[w][4]);
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int w = 0; w < 5; w++) begin
      for (int r = 0; r < 5; r++) begin
        mPend[w][r] = '0;
        mAct[w][r] = '0;
      end
      mActEnd[w] = '0;
    end
    mProt = '0;
    mEn = '0;
  endtask

  task automatic modelStep(input logic we, input logic [7:0] a, input logic [31:0] d,
                           input logic vs);
    int w = int'(a[7:4]);
    int r = int'(a[3:0]);
    if (vs)
      for (int i = 0; i < 5; i++)
        if (!mProt[i]) begin
          for (int k = 0; k < 5; k++) mAct[i][k] = mPend[i][k];
          mActEnd[i] = endOf(mPend[i][1], mPend[i][2], mPend[i][4]);
        end
    if (we) begin
      if (w == 15 && r == 0) begin
        mEn = d[4:0];
        mProt = d[12:8];
      end else if (w < 5 && r < 5) begin
        mPend[w][r] = (r == 3 || r == 4) ? (d & 32'h0FFF_0FFF) : d;
      end
    end
  endtask

  task automatic checkActive(input string tag);
    for (int i = 0; i < 5; i++) begin
      chk({tag, " ctrl"},   actCtrl[i*32 +: 32],   mAct[i][0]);
      chk({tag, " start"},  actStart[i*32 +: 32],  mAct[i][1]);
      chk({tag, " stride"}, actStride[i*32 +: 32], mAct[i][2]);
      chk({tag, " pos"},    actPos[i*32 +: 32],    mAct[i][3]);
      chk({tag, " size"},   actSize[i*32 +: 32],   mAct[i][4]);
      chk({tag, " end"},    actEnd[i*32 +: 32],    mActEnd[i]);
    end
    chk({tag, " chanEn"}, {27'b0, chanEn}, {27'b0, mEn});
  endtask

  task automatic checkRead(input string tag, input logic [7:0] a);
    rdAddr = a;
    #1;
    chk(tag, rdData, readExp(a));
  endtask

  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic vs);
    wrEn = we;
    wrAddr = a;
    wrData = d;
    vsyncStart = vs;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    vsyncStart = 1'b0;
    modelStep(we, a, d, vs);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    checkActive("R1 reset");
    checkRead("R1 reset read start", 8'h01);
    checkRead("R1 reset read global", 8'hF0);

    cycle(1, 8'h01, 32'h0000_1000, 0);
    cycle(1, 8'h02, 32'h0010_0040, 0);
    cycle(1, 8'h04, 32'h0003_0010, 0);
    checkRead("R2 readback start", 8'h01);
    checkActive("R2 no vsync");
    checkRead("R7 end read", 8'h05);
    chk("R7 end value", rdData, 32'h0000_10F0);
    cycle(0, 8'h00, 32'h0, 1);
    checkActive("R3 vsync copy");
    chk("R7 actEnd", actEnd[31:0], 32'h0000_10F0);

    cycle(1, 8'hF0, 32'h0000_0400, 0);
    cycle(1, 8'h21, 32'hABCD_0000, 0);
    cycle(1, 8'h01, 32'h0000_2000, 0);
    cycle(0, 8'h00, 32'h0, 1);
    checkActive("R4 protected");
    chk("R4 w2 start held", actStart[64 +: 32], 32'h0);
    chk("R3 w0 copied", actStart[31:0], 32'h0000_2000);
    cycle(1, 8'hF0, 32'h0000_0000, 0);
    checkActive("R5 before vsync");
    chk("R5 w2 still old", actStart[64 +: 32], 32'h0);
    cycle(0, 8'h00, 32'h0, 1);
    chk("R5 w2 copied", actStart[64 +: 32], 32'hABCD_0000);
    checkActive("R5 after vsync");

    cycle(1, 8'hF0, 32'h0000_1F1F, 0);
    chk("R6 chanEn", {27'b0, chanEn}, 32'h1F);
    checkRead("R6 global read", 8'hF0);
    cycle(1, 8'hF0, 32'hFFFF_E0E5, 0);
    checkRead("R6 reserved bits zero", 8'hF0);
    chk("R6 value", rdData, 32'h0000_0005);
    checkActive("R6 no copy");

    cycle(1, 8'hF0, 32'h0, 0);
    cycle(1, 8'h31, 32'h5555_0000, 1);
    checkActive("R10 same-cycle");
    chk("R10 old value copied", actStart[96 +: 32], 32'h0);
    cycle(1, 8'hF0, 32'h0000_0800, 1);
    checkActive("R10 prot same-cycle");
    chk("R10 protect late", actStart[96 +: 32], 32'h5555_0000);

    cycle(1, 8'h13, 32'hFFFF_FFFF, 0);
    checkRead("R8 pos mask", 8'h13);
    chk("R8 pos value", rdData, 32'h0FFF_0FFF);
    cycle(1, 8'h14, 32'hF123_F456, 0);
    checkRead("R8 size mask", 8'h14);

    cycle(1, 8'h05, 32'h1234_5678, 0);
    checkRead("R9 end write ignored", 8'h05);
    cycle(1, 8'h07, 32'h1234_5678, 0);
    checkRead("R9 reg7 read zero", 8'h07);
    cycle(1, 8'h51, 32'h1234_5678, 0);
    checkRead("R9 win5 read zero", 8'h51);
    for (int w = 0; w < 5; w++)
      for (int r = 0; r < 6; r++)
        checkRead("R9 no side effect", {w[3:0], r[3:0]});

    void'($urandom(32'h5EED_1234));
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] a;
      logic [31:0] d = $urandom();
      a = {4'($urandom_range(0, 6)), 4'($urandom_range(0, 6))};
      if (op <= 5) cycle(1, a, d, 0);
      else if (op == 6) cycle(1, 8'hF0, d, 0);
      else if (op <= 8) cycle(0, 8'h00, 32'h0, 1);
      else cycle(1, a, d, 1);
      checkActive("R3 random");
      checkRead("R2 random read", a);
      checkRead("R7 random end", {a[7:4], 4'd5});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule